// File: doc/BRIEF.md
# Secondary Sync Group-Index Search

This block finishes the cell search of a new-radio receiver. The primary detector has already settled the sector index (0 to 2). This block then takes the 127 received values of the secondary signal and finds the group index (0 to 335) whose gold sequence matches them best. A start pulse arms the block and latches the sector index. The next 127 samples flagged valid are stored in order. The block then sweeps all 336 candidate sequences, one per clock cycle, and reports the winning group index, its correlation magnitude and the physical cell identity.

Each candidate is built from two 127-chip maximal-length sequences. After reset, two small shift-register generators fill both sequences into registers. Each candidate then takes a cyclic shift of each sequence, XORs them, and maps the result to ±1 chips.

Top module: `sss_group_search`

## Requirements
- R1: After reset, `done_o` is low and `group_o`, `peak_o` and `cell_id_o` are all zero.
- R2: A start pulse accepted in idle latches `sector_i`. The next 127 cycles that have `sample_valid_i` high supply samples s[0]..s[126] in that order. Cycles with `sample_valid_i` low store nothing.
- R3: Sequence A follows a(i+7) = a(i+4) XOR a(i). Sequence B follows b(i+7) = b(i+1) XOR b(i). Both start from (x(0)..x(6)) = (1,0,0,0,0,0,0). Both are fixed in registers before the first start is accepted; starts during that fill are ignored.
- R4: For group g and sector k, the shifts are mA = 15·floor(g/112) + 5·k and mB = g mod 112. Chip n is +1 when a((n+mA) mod 127) equals b((n+mB) mod 127), and −1 otherwise.
- R5: The metric of a candidate is the absolute value of the sum over n of s[n]·chip(n). `peak_o` shows the metric of the winning group.
- R6: The winner is the group with the largest metric. On equal metrics the lower group index wins, so an all-zero input gives group 0 with peak 0.
- R7: `cell_id_o` equals 3·group + sector, in the range 0 to 1007.
- R8: `done_o` is high for exactly one cycle. It rises on the 336th rising edge after the edge that stored s[126], and the results are valid while it is high.
- R9: A start pulse that arrives while samples are being collected or during the sweep has no effect on the sector used or on the result.
- R10: After `done_o`, the results hold until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arms a search; accepted only when idle and ready |
| sector_i | input | 2 | Sector index from the primary detector |
| sample_valid_i | input | 1 | Qualifies `sample_i` |
| sample_i | input | SAMPLE_W | Signed received secondary-signal value |
| group_o | output | 9 | Winning group index |
| peak_o | output | SAMPLE_W+8 | Correlation magnitude of the winner |
| cell_id_o | output | 10 | Physical cell identity |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with the default 12-bit samples and the full set of 336 candidates. At one candidate per cycle, a full sweep takes 336 cycles, so many complete searches fit in a short run. These include the top corner (group 335, sector 2, identity 1007), a negated input that checks the absolute value, an all-zero input that checks the tie rule, and near full-scale amplitudes that use the full accumulator width. Random frames with gaps in the valid flag and stray start pulses are checked against a bench model that regenerates both sequences from their recurrences.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int SEQ_LEN    = 127;
  localparam int NUM_GROUPS = 336;
  localparam int ROW_SIZE   = 112;
  localparam int IDX_W      = 7;
  localparam int GRP_W      = 9;
  localparam int CID_W      = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_CAPT, ST_SWEEP} srch_state_t;

  // Shift applied to sequence A for a given group and sector
  function automatic logic [IDX_W-1:0] shift_a(logic [GRP_W-1:0] grp, logic [1:0] sec);
    int v;
    v = 15 * (int'(grp) / ROW_SIZE) + 5 * int'(sec);
    return IDX_W'(v);
  endfunction

  // Shift applied to sequence B for a given group
  function automatic logic [IDX_W-1:0] shift_b(logic [GRP_W-1:0] grp);
    return IDX_W'(int'(grp) % ROW_SIZE);
  endfunction

  function automatic logic [CID_W-1:0] cell_of(logic [GRP_W-1:0] grp, logic [1:0] sec);
    return CID_W'(3 * int'(grp) + int'(sec));
  endfunction

  // Cyclic rotation: bit n of result = bit (n+m) mod 127 of s
  function automatic logic [SEQ_LEN-1:0] rot_seq(logic [SEQ_LEN-1:0] s, logic [IDX_W-1:0] m);
    return SEQ_LEN'({s, s} >> m);
  endfunction
endpackage

// File: rtl/sss_mseq_gen.sv
module sss_mseq_gen #(
  parameter int TAP = 4,
  parameter int LEN = 127
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [LEN-1:0] seq_o,
  output logic           ready_o
);
  localparam int CW = $clog2(LEN);

  logic [6:0]    win_q;   // win_q[j] = x(i+j)
  logic [CW-1:0] cnt_q;
  logic [LEN-1:0] seq_q;
  logic          ready_q;
  logic          fb;

  assign fb = win_q[TAP] ^ win_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= 7'b0000001;
      cnt_q   <= '0;
      seq_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      seq_q[cnt_q] <= win_q[0];
      win_q        <= {fb, win_q[6:1]};
      if (cnt_q == CW'(LEN-1)) ready_q <= 1'b1;
      else                     cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign seq_o   = seq_q;
  assign ready_o = ready_q;

  AST_SEQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> (ready_q && $stable(seq_q))); // R3
endmodule

// File: rtl/sss_sample_buf.sv
module sss_sample_buf #(
  parameter int SW  = 12,
  parameter int LEN = 127
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(LEN)-1:0]  wr_idx,
  input  logic [SW-1:0]           wr_data,
  output logic [LEN-1:0][SW-1:0]  buf_o
);
  logic [LEN-1:0][SW-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mem_q         <= '0;
    else if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign buf_o = mem_q;
endmodule

// File: rtl/sss_corr.sv
module sss_corr #(
  parameter int SW  = 12,
  parameter int LEN = 127,
  parameter int MW  = SW + 8
) (
  input  logic [LEN-1:0][SW-1:0] samples,
  input  logic [LEN-1:0]         code_a,
  input  logic [LEN-1:0]         code_b,
  output logic [MW-1:0]          metric
);
  logic signed [MW-1:0] acc;
  logic signed [MW-1:0] ext;

  always_comb begin
    acc = '0;
    ext = '0;
    for (int n = 0; n < LEN; n++) begin
      ext = {{(MW-SW){samples[n][SW-1]}}, samples[n]};
      if (code_a[n] ^ code_b[n]) acc = acc - ext;
      else                       acc = acc + ext;
    end
    metric = acc[MW-1] ? MW'(-acc) : MW'(acc);
  end
endmodule

// File: rtl/sss_group_search.sv
module sss_group_search
  import sss_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [1:0]            sector_i,
  input  logic                  sample_valid_i,
  input  logic [SAMPLE_W-1:0]   sample_i,
  output logic [GRP_W-1:0]      group_o,
  output logic [SAMPLE_W+7:0]   peak_o,
  output logic [CID_W-1:0]      cell_id_o,
  output logic                  done_o
);
  localparam int MW = SAMPLE_W + 8;

  srch_state_t        state_q;
  logic [1:0]         sec_q;
  logic [IDX_W-1:0]   wr_idx_q;
  logic [GRP_W-1:0]   grp_q;
  logic [GRP_W-1:0]   best_grp_q;
  logic [MW-1:0]      best_pk_q;
  logic               done_q;

  logic [SEQ_LEN-1:0] seq_a, seq_b, code_a, code_b;
  logic               rdy_a, rdy_b;
  logic [SEQ_LEN-1:0][SAMPLE_W-1:0] samples;
  logic [MW-1:0]      cand_metric;

  // Named internal events
  logic start_acc, cap_fire, cap_last, sweep_last, cand_better;

  assign start_acc   = start_i && (state_q == ST_IDLE) && rdy_a && rdy_b;
  assign cap_fire    = (state_q == ST_CAPT) && sample_valid_i;
  assign cap_last    = cap_fire && (wr_idx_q == IDX_W'(SEQ_LEN-1));
  assign sweep_last  = (state_q == ST_SWEEP) && (grp_q == GRP_W'(NUM_GROUPS-1));
  assign cand_better = (state_q == ST_SWEEP) && (cand_metric > best_pk_q);

  sss_mseq_gen #(.TAP(4), .LEN(SEQ_LEN)) u_gen_a (
    .clk(clk), .rst_n(rst_n), .seq_o(seq_a), .ready_o(rdy_a));
  sss_mseq_gen #(.TAP(1), .LEN(SEQ_LEN)) u_gen_b (
    .clk(clk), .rst_n(rst_n), .seq_o(seq_b), .ready_o(rdy_b));

  sss_sample_buf #(.SW(SAMPLE_W), .LEN(SEQ_LEN)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(cap_fire), .wr_idx(wr_idx_q),
    .wr_data(sample_i), .buf_o(samples));

  assign code_a = rot_seq(seq_a, shift_a(grp_q, sec_q));
  assign code_b = rot_seq(seq_b, shift_b(grp_q));

  sss_corr #(.SW(SAMPLE_W), .LEN(SEQ_LEN), .MW(MW)) u_corr (
    .samples(samples), .code_a(code_a), .code_b(code_b), .metric(cand_metric));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sec_q      <= '0;
      wr_idx_q   <= '0;
      grp_q      <= '0;
      best_grp_q <= '0;
      best_pk_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= sweep_last;
      unique case (state_q)
        ST_IDLE: if (start_acc) begin
          sec_q      <= sector_i;
          wr_idx_q   <= '0;
          best_grp_q <= '0;
          best_pk_q  <= '0;
          state_q    <= ST_CAPT;
        end
        ST_CAPT: if (cap_fire) begin
          if (cap_last) begin
            grp_q   <= '0;
            state_q <= ST_SWEEP;
          end else begin
            wr_idx_q <= wr_idx_q + 1'b1;
          end
        end
        ST_SWEEP: begin
          if (cand_better) begin
            best_pk_q  <= cand_metric;
            best_grp_q <= grp_q;
          end
          if (sweep_last) state_q <= ST_IDLE;
          else            grp_q   <= grp_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign group_o   = best_grp_q;
  assign peak_o    = best_pk_q;
  assign cell_id_o = cell_of(best_grp_q, sec_q);
  assign done_o    = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> $stable(sec_q)); // R9
  AST_PEAK_NONDECREASING: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SWEEP) |=> (best_pk_q >= $past(best_pk_q))); // R6
  AST_CELL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cell_id_o <= CID_W'(1007))); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_acc) |=> ($stable(best_grp_q) && $stable(best_pk_q))); // R10
  AST_GROUP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    grp_q < GRP_W'(NUM_GROUPS)); // R4
endmodule

// File: tb/sss_group_search_tb.sv
module sss_group_search_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] sector_i = '0;
  logic sample_valid_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic [8:0] group_o;
  logic [19:0] peak_o;
  logic [9:0] cell_id_o;
  logic done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int xa[134];
  int xb[134];
  int samp[127];

  always #2.5 clk = ~clk;

  sss_group_search #(.SAMPLE_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sector_i(sector_i),
    .sample_valid_i(sample_valid_i), .sample_i(sample_i),
    .group_o(group_o), .peak_o(peak_o), .cell_id_o(cell_id_o), .done_o(done_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 chip value from the recurrences
  function automatic int chip(int g, int k, int n);
    int ma, mb;
    ma = 15 * (g / 112) + 5 * k;
    mb = g % 112;
    return (xa[(n + ma) % 127] == xb[(n + mb) % 127]) ? 1 : -1;
  endfunction

  // R5/R6 reference search
  task automatic model(input int k, output int bg, output int bp);
    bg = 0; bp = -1;
    for (int g = 0; g < 336; g++) begin
      int s = 0;
      for (int n = 0; n < 127; n++) s += samp[n] * chip(g, k, n);
      if (s < 0) s = -s;
      if (s > bp) begin bp = s; bg = g; end
    end
  endtask

  task automatic build(input int g, input int k, input int amp, input int noise);
    for (int n = 0; n < 127; n++) begin
      int v = amp * chip(g, k, n);
      if (noise > 0) v += $urandom_range(0, 2 * noise) - noise;
      if (v > 2047) v = 2047;
      if (v < -2048) v = -2048;
      samp[n] = v;
    end
  endtask

  task automatic run_frame(input int k, input bit poke);
    int eg, ep, cnt, hg;
    model(k, eg, ep);
    @(negedge clk); start_i = 1'b1; sector_i = 2'(k);
    @(negedge clk); start_i = 1'b0;
    for (int n = 0; n < 127; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        sample_valid_i = 1'b0; sample_i = 12'($urandom);
        @(negedge clk);
      end
      sample_valid_i = 1'b1; sample_i = 12'(samp[n]);
      start_i = poke && (n == 40);           // R9 stray start while collecting
      sector_i = poke && (n == 40) ? 2'(3 - k) : 2'(k);
      @(negedge clk);
      start_i = 1'b0;
    end
    sample_valid_i = 1'b0;
    cnt = 0;
    while (!done_o && cnt < 400) begin
      @(negedge clk); cnt++;
      if (poke && cnt == 100) begin start_i = 1'b1; sector_i = 2'(3 - k); end  // R9 during sweep
      else start_i = 1'b0;
      if (poke && cnt == 101) begin sample_valid_i = 1'b1; sample_i = 12'h7FF; end
      else sample_valid_i = 1'b0;
    end
    start_i = 1'b0; sample_valid_i = 1'b0;
    check(cnt == 336, "R8 latency", cnt, 336);
    check(int'(group_o) == eg, poke ? "R9 group" : "R6 group", int'(group_o), eg);
    check(int'(peak_o) == ep, "R5 peak", int'(peak_o), ep);
    check(int'(cell_id_o) == 3 * eg + k, "R7 cell", int'(cell_id_o), 3 * eg + k);
    hg = int'(group_o);
    @(negedge clk);
    check(done_o == 1'b0, "R8 pulse width", int'(done_o), 0);
    repeat (5) @(negedge clk);
    check(int'(group_o) == hg && int'(peak_o) == ep, "R10 hold", int'(group_o), hg);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 7; i++) begin xa[i] = (i == 0); xb[i] = (i == 0); end
    for (int i = 0; i < 127; i++) begin       // R3 recurrences
      xa[i + 7] = xa[i + 4] ^ xa[i];
      xb[i + 7] = xb[i + 1] ^ xb[i];
    end
    repeat (3) @(negedge clk);
    check(done_o == 1'b0 && group_o == '0 && peak_o == '0 && cell_id_o == '0,
          "R1 reset", int'(cell_id_o), 0);
    rst_n = 1'b1;
    repeat (160) @(negedge clk);
    build(0, 0, 300, 0);     run_frame(0, 0);            // R2 lowest corner
    build(335, 2, 900, 40);  run_frame(2, 0);            // R7 id 1007
    build(200, 1, -500, 30); run_frame(1, 0);            // R5 negated input
    build(0, 0, 0, 0);       run_frame(1, 0);            // R6 tie -> group 0
    build(17, 0, 2000, 0);   run_frame(0, 0);            // R5 near full scale
    for (int f = 0; f < 5; f++) begin
      int g = $urandom_range(0, 335);
      int k = $urandom_range(0, 2);
      build(g, k, $urandom_range(40, 400), $urandom_range(0, 150));
      run_frame(k, f[0]);                                 // R4 random groups
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule